// File: doc/BRIEF.md
# Split-Capable Auto-Reload Capture Timer

This block is a 16-bit timer built from a low and a high byte, each with its own reload byte. It works in one of three ways, chosen by a control byte. As a single 16-bit counter it reloads from the full reload value when it wraps. As two independent 8-bit counters each byte reloads from its own reload byte. In capture mode the reload bytes become capture registers: a selected event copies the live count into them.

Count ticks are produced inside the block. Each byte either advances every system clock cycle or on a prescaled tick. The prescaled tick is the system clock divided by 12, or external oscillator pulses divided by 8. The external pulses arrive as single-cycle enables that are already synchronous to the system clock. The capture event is either a synchronous start-of-frame pulse or the rising edge of a raw low-frequency oscillator input, which the block resynchronizes. Two sticky overflow flags and a gated interrupt request report to the CPU side.

Top module: `split_capture_timer`

## Requirements
- R1: After reset the control byte (`ctrl_o`), count and reload are all zero and `irq_o` is low. Control byte fields, from bit 7 down to bit 0, are: high flag, low flag, low interrupt enable, capture enable, split, run, capture source, prescale source.
- R2: With split = 0 and capture enable = 0, the 16-bit count advances by one per low-byte tick while run = 1. An advance from 0xFFFF loads the 16-bit reload value and sets the high flag (bit 7).
- R3: An advance of the low byte from 0xFF sets the low flag (bit 6) in every mode. In 16-bit mode this happens even when the high byte does not wrap, for example 0x12FF to 0x1300.
- R4: Both flags stay set until a control write places 0 in them. A control write loads every control bit from `wr_data_i`, and a hardware set in the same cycle wins.
- R5: `irq_o` is high only when `irq_en_i` is high and either the high flag is set, or the low flag and the low interrupt enable (bit 5) are both set.
- R6: With split = 1, the low byte advances on every low tick whatever the run bit. The high byte advances only while run = 1. Each byte reloads from its own reload byte when it advances from 0xFF, and sets its own flag.
- R7: With split = 0 and run = 0, the count does not change, except by a direct count write.
- R8: With capture enable (bit 4) = 1, a capture event copies the count into reload and sets the high flag. It overrides a reload write in the same cycle. In this mode the counter wraps to zero instead of reloading.
- R9: Capture source (bit 1) = 0 takes `sof_i` pulses as events and ignores `lfo_i`. Capture source = 1 takes each rising edge of `lfo_i` as exactly one event, after a two-flop synchronizer, so a held-high level gives no further events.
- R10: A byte whose prescale select input is 0 ticks every cycle. With the select at 1 it ticks on the prescaled tick: one tick per 12 system cycles when bit 0 = 0, and one tick per 8 `ext_pulse_i` pulses when bit 0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 8 | Shared write data for all write strobes |
| ctrl_we_i | input | 1 | Write the control byte |
| rld_lo_we_i | input | 1 | Write the low reload byte |
| rld_hi_we_i | input | 1 | Write the high reload byte |
| cnt_lo_we_i | input | 1 | Write the low count byte |
| cnt_hi_we_i | input | 1 | Write the high count byte |
| lo_presc_i | input | 1 | Low byte tick select: 0 system clock, 1 prescaled tick |
| hi_presc_i | input | 1 | High byte tick select: 0 system clock, 1 prescaled tick |
| ext_pulse_i | input | 1 | Synchronous external oscillator enable pulse |
| sof_i | input | 1 | Start-of-frame event pulse |
| lfo_i | input | 1 | Raw low-frequency oscillator level |
| irq_en_i | input | 1 | Timer interrupt enable from the interrupt controller |
| ctrl_o | output | 8 | Control byte read value |
| count_o | output | 16 | Current count {high, low} |
| reload_o | output | 16 | Reload or capture value {high, low} |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong mode or tick decode shows up on `count_o` within one or two ticks. The count either moves when it should be frozen, or lands on the wrong value after a wrap, because it reloads where it should wrap freely or the other way round. A wrong flag update shows on `ctrl_o` at the next read, and on `irq_o` in the same cycle, because the request is combinational from the flag state. Capture faults show on `reload_o` one cycle after a `sof_i` pulse, or three cycles after an `lfo_i` edge. That includes a missed event, a second capture from a held level, or a lost priority over a reload write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic hi_flag;
    logic lo_flag;
    logic lo_ie;
    logic cap_en;
    logic split;
    logic run;
    logic cap_src;
    logic clk_sel;
  } ctrl_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = 2;
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int unsigned SYS_DIV = 12,
  parameter int unsigned EXT_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_pulse_i,
  input  logic clk_sel_i,
  output logic tick_o
);
  localparam int unsigned SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic [SW-1:0] sys_q;
  logic [EW-1:0] ext_q;
  logic sys_tick, ext_tick;

  assign sys_tick = (sys_q == SYS_LAST);
  assign ext_tick = ext_pulse_i && (ext_q == EXT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= '0;
      ext_q <= '0;
    end else begin
      sys_q <= sys_tick ? '0 : sys_q + 1'b1;
      if (ext_pulse_i) ext_q <= ext_tick ? '0 : ext_q + 1'b1;
    end
  end

  assign tick_o = clk_sel_i ? ext_tick : sys_tick;
endmodule

// File: rtl/timer_cap_event.sv
module timer_cap_event #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic src_i,
  input  logic sof_i,
  input  logic lfo_i,
  output logic cap_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lfo_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], lfo_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lfo_rise = sync_q[SYNC_STAGES-1] && !last_q;
  assign cap_o    = en_i && (src_i ? lfo_rise : sof_i);
endmodule

// File: rtl/timer_byte_cnt.sv
module timer_byte_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         reload_ok_i,
  input  logic [W-1:0] rld_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);
  logic [W-1:0] cnt_q;

  assign max_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (wr_i)        cnt_q <= wdata_i;
    else if (adv_i) begin
      if (max_o && reload_ok_i) cnt_q <= rld_i;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/split_capture_timer.sv
module split_capture_timer
  import timer_pkg::*;
#(
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  wr_data_i,
  input  logic        ctrl_we_i,
  input  logic        rld_lo_we_i,
  input  logic        rld_hi_we_i,
  input  logic        cnt_lo_we_i,
  input  logic        cnt_hi_we_i,
  input  logic        lo_presc_i,
  input  logic        hi_presc_i,
  input  logic        ext_pulse_i,
  input  logic        sof_i,
  input  logic        lfo_i,
  input  logic        irq_en_i,
  output logic [7:0]  ctrl_o,
  output logic [15:0] count_o,
  output logic [15:0] reload_o,
  output logic        irq_o
);
  ctrl_t ctrl_q, ctrl_wr;
  logic presc_tick, lo_tick, hi_tick, cap_pulse;
  logic lo_wrap, hi_wrap;

  logic [NBYTES-1:0]             adv, reload_ok, max_b, cnt_we, rld_we;
  logic [NBYTES-1:0][BYTE_W-1:0] cnt_b, rld_q;

  timer_tick_gen #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_tick (
    .clk_i, .rst_ni, .ext_pulse_i,
    .clk_sel_i (ctrl_q.clk_sel),
    .tick_o    (presc_tick)
  );

  timer_cap_event #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i, .rst_ni, .sof_i, .lfo_i,
    .en_i  (ctrl_q.cap_en),
    .src_i (ctrl_q.cap_src),
    .cap_o (cap_pulse)
  );

  assign lo_tick = lo_presc_i ? presc_tick : 1'b1;
  assign hi_tick = hi_presc_i ? presc_tick : 1'b1;

  // split: low byte free-running, run gates high only; 16-bit: high carries from low
  assign adv[0] = ctrl_q.split ? lo_tick : (ctrl_q.run && lo_tick);
  assign adv[1] = ctrl_q.split ? (ctrl_q.run && hi_tick)
                               : (ctrl_q.run && lo_tick && max_b[0]);

  assign hi_wrap = adv[1] && max_b[1];
  assign lo_wrap = adv[0] && max_b[0];

  assign reload_ok[0] = !ctrl_q.cap_en && (ctrl_q.split || max_b[1]);
  assign reload_ok[1] = !ctrl_q.cap_en;

  assign cnt_we = {cnt_hi_we_i, cnt_lo_we_i};
  assign rld_we = {rld_hi_we_i, rld_lo_we_i};

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    timer_byte_cnt #(.W(BYTE_W)) u_cnt (
      .clk_i, .rst_ni,
      .adv_i       (adv[b]),
      .reload_ok_i (reload_ok[b]),
      .rld_i       (rld_q[b]),
      .wr_i        (cnt_we[b]),
      .wdata_i     (wr_data_i),
      .cnt_o       (cnt_b[b]),
      .max_o       (max_b[b])
    );

    // capture beats a software reload write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rld_q[b] <= '0;
      else if (cap_pulse) rld_q[b] <= cnt_b[b];
      else if (rld_we[b]) rld_q[b] <= wr_data_i;
    end
  end

  always_comb begin
    ctrl_wr = ctrl_we_i ? ctrl_t'(wr_data_i) : ctrl_q;
    ctrl_wr.hi_flag = ctrl_wr.hi_flag | hi_wrap | cap_pulse;
    ctrl_wr.lo_flag = ctrl_wr.lo_flag | lo_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_wr;
  end

  assign ctrl_o   = ctrl_q;
  assign count_o  = cnt_b;
  assign reload_o = rld_q;
  assign irq_o    = irq_en_i && (ctrl_q.hi_flag || (ctrl_q.lo_flag && ctrl_q.lo_ie));
endmodule

// File: rtl/timer_chk.sv
module timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic        cnt_lo_we_i,
  input logic        cnt_hi_we_i,
  input logic        sof_i,
  input logic        irq_en_i,
  input logic [7:0]  ctrl_o,
  input logic [15:0] count_o,
  input logic [15:0] reload_o,
  input logic        irq_o
);
  // R4
  hi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && !ctrl_we_i) |=> ctrl_o[7]);

  // R4
  lo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[6] && !ctrl_we_i) |=> ctrl_o[6]);

  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  // R5
  irq_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && ctrl_o[7]) |-> irq_o);

  // R7
  stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[3] && !ctrl_o[2] && !cnt_lo_we_i && !cnt_hi_we_i) |=> $stable(count_o));

  // R8
  sof_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[4] && !ctrl_o[1] && sof_i) |=> (reload_o == $past(count_o)) && ctrl_o[7]);
endmodule

bind split_capture_timer timer_chk u_timer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .cnt_lo_we_i (cnt_lo_we_i),
  .cnt_hi_we_i (cnt_hi_we_i),
  .sof_i       (sof_i),
  .irq_en_i    (irq_en_i),
  .ctrl_o      (ctrl_o),
  .count_o     (count_o),
  .reload_o    (reload_o),
  .irq_o       (irq_o)
);

// File: tb/tb_split_capture_timer.sv
`timescale 1ns/1ps
module tb_split_capture_timer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] wr_data = '0;
  logic ctrl_we = 0, rld_lo_we = 0, rld_hi_we = 0, cnt_lo_we = 0, cnt_hi_we = 0;
  logic lo_presc = 0, hi_presc = 0, ext_pulse = 0, sof = 0, lfo = 0, irq_en = 0;
  logic [7:0] ctrl;
  logic [15:0] count, reload;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_capture_timer dut (
    .clk_i(clk), .rst_ni, .wr_data_i(wr_data), .ctrl_we_i(ctrl_we),
    .rld_lo_we_i(rld_lo_we), .rld_hi_we_i(rld_hi_we),
    .cnt_lo_we_i(cnt_lo_we), .cnt_hi_we_i(cnt_hi_we),
    .lo_presc_i(lo_presc), .hi_presc_i(hi_presc), .ext_pulse_i(ext_pulse),
    .sof_i(sof), .lfo_i(lfo), .irq_en_i(irq_en),
    .ctrl_o(ctrl), .count_o(count), .reload_o(reload), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // all tasks start and end at a negedge
  task automatic wr_ctrl(input logic [7:0] d);
    wr_data = d; ctrl_we = 1; @(negedge clk); ctrl_we = 0;
  endtask

  task automatic set_count(input logic [15:0] v);
    wr_data = v[7:0]; cnt_lo_we = 1; @(negedge clk); cnt_lo_we = 0;
    wr_data = v[15:8]; cnt_hi_we = 1; @(negedge clk); cnt_hi_we = 0;
  endtask

  task automatic set_reload(input logic [15:0] v);
    wr_data = v[7:0]; rld_lo_we = 1; @(negedge clk); rld_lo_we = 0;
    wr_data = v[15:8]; rld_hi_we = 1; @(negedge clk); rld_hi_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", {8'h0, ctrl}, 16'h0);
    chk("R1 count", count, 16'h0);
    chk("R1 reload", reload, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_reload16();
    logic [15:0] held;
    set_reload(16'hFFF0);
    set_count(16'hFFFD);
    wr_ctrl(8'h04);
    cycles(3);
    chk("R2 reload on full wrap", count, 16'hFFF0);
    chk("R2 high flag", {15'h0, ctrl[7]}, 16'h1);
    chk("R3 low flag on full wrap", {15'h0, ctrl[6]}, 16'h1);
    wr_ctrl(8'hC0);
    held = count;
    cycles(5);
    chk("R7 stopped count holds", count, held);
    chk("R4 flags sticky", {8'h0, ctrl}, 16'h00C0);
    wr_ctrl(8'h00);
    chk("R4 flags cleared by write", {8'h0, ctrl}, 16'h0);
  endtask

  task automatic t_lowwrap16();
    set_count(16'h12FE);
    wr_ctrl(8'h04);
    cycles(2);
    chk("R3 low wrap in 16-bit count", count, 16'h1300);
    chk("R3 low flag only", {8'h0, ctrl}, 16'h0044);
    wr_ctrl(8'h00);
  endtask

  task automatic t_irq();
    irq_en = 1;
    wr_ctrl(8'h40);
    chk("R5 low flag without enable", {15'h0, irq}, 16'h0);
    wr_ctrl(8'h60);
    chk("R5 low flag with enable", {15'h0, irq}, 16'h1);
    wr_ctrl(8'h80);
    chk("R5 high flag", {15'h0, irq}, 16'h1);
    irq_en = 0; #1;
    chk("R5 gated by irq_en", {15'h0, irq}, 16'h0);
    @(negedge clk);
    wr_ctrl(8'h00);
  endtask

  task automatic t_split();
    set_reload(16'h1080);
    set_count(16'hFEFE);
    wr_ctrl(8'h08);
    cycles(2);
    chk("R6 low reloads own byte, high held", count, 16'hFE80);
    chk("R6 low flag only", {8'h0, ctrl}, 16'h0048);
    wr_ctrl(8'h0C);
    cycles(2);
    chk("R6 high reloads own byte under run", count, 16'h1083);
    chk("R6 high flag", {15'h0, ctrl[7]}, 16'h1);
    wr_ctrl(8'h00);
  endtask

  task automatic t_capture();
    set_count(16'h1234);
    wr_ctrl(8'h10);
    sof = 1; @(negedge clk); sof = 0;
    chk("R8 sof capture", reload, 16'h1234);
    chk("R8 capture sets high flag", {8'h0, ctrl}, 16'h0090);
    set_count(16'h5555);
    lfo = 1; cycles(5);
    chk("R9 lfo ignored when source 0", reload, 16'h1234);
    lfo = 0; cycles(3);
    wr_ctrl(8'h10);
    wr_data = 8'hAA; rld_lo_we = 1; sof = 1; @(negedge clk); rld_lo_we = 0; sof = 0;
    chk("R8 capture beats reload write", reload, 16'h5555);
    wr_ctrl(8'h12);
    set_count(16'h9ABC);
    lfo = 1; cycles(5);
    chk("R9 lfo edge capture", reload, 16'h9ABC);
    chk("R9 lfo capture flag", {15'h0, ctrl[7]}, 16'h1);
    wr_ctrl(8'h12);
    set_count(16'h1111);
    cycles(5);
    chk("R9 held level no second capture", reload, 16'h9ABC);
    chk("R9 no flag from held level", {15'h0, ctrl[7]}, 16'h0);
    lfo = 0; cycles(3);
    set_count(16'hFFFE);
    wr_ctrl(8'h14);
    cycles(2);
    chk("R8 free wrap in capture mode", count, 16'h0000);
    chk("R8 reload untouched by wrap", reload, 16'h9ABC);
    wr_ctrl(8'h00);
  endtask

  task automatic t_presc();
    set_count(16'h0000);
    lo_presc = 1;
    wr_ctrl(8'h04);
    cycles(24);
    chk("R10 sysclk/12 gives 2 ticks in 24 cycles", count, 16'h0002);
    wr_ctrl(8'h00);
    set_count(16'h0000);
    wr_ctrl(8'h05);
    cycles(30);
    chk("R10 no tick without ext pulses", count, 16'h0000);
    repeat (16) begin
      ext_pulse = 1; @(negedge clk); ext_pulse = 0; @(negedge clk);
    end
    chk("R10 ext/8 gives 2 ticks in 16 pulses", count, 16'h0002);
    wr_ctrl(8'h00);
    lo_presc = 0;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_reload16();
    t_lowwrap16();
    t_irq();
    t_split();
    t_capture();
    t_presc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule